// File: doc/BRIEF.md
# SDRAM Burst Data Path with Byte-Lane Masking

This block carries data between a host and a 64-bit SDRAM data bus. A separate sequencer issues commands to the memory. It reports each read, write and burst-stop command to this block in the same cycle it issues it. For every write beat the block routes the host word onto the bus and enables only the byte lanes the host leaves unmasked, all in the beat's own cycle. For reads it schedules each beat, carries the beat's column number through a pipeline matched to a CAS latency of three, and captures the bus three edges after the beat is issued.

Eight byte-mask lines pass straight from the host to the memory. The block applies the memory's asymmetric mask timing. A mask seen on a write edge blocks that edge's lane. A mask seen on a read edge blinds the lane captured two edges later, and that lane comes back zeroed and flagged invalid. Bursts of 1, 2, 4 or 8 beats follow sequential or interleaved column order. A burst-stop command or a fresh command cuts the current burst short. Beats already in flight still arrive.

Top module: `sdram_datapath`

## Requirements
- R1: While reset is asserted and after its release with no command, `wrTake`, `rdValid` and every `dqOe` bit are 0.
- R2: In each write beat cycle `wrTake` is 1, `dqOut` equals `hostWrData` and `dqOe` bit n equals the inverse of `hostMask` bit n (write mask latency 0). In the cycle after the last write beat every `dqOe` bit is 0.
- R3: `cfgBurst` value b (0..3), sampled with a command, gives a burst of 2^b beats: the command cycle plus 2^b-1 following cycles, unless cut short.
- R4: With `cfgInterleave`=0, starting column s and burst length L, beat i carries column (s AND NOT(L-1)) OR ((s+i) AND (L-1)), on `beatCol` and later on `rdCol`.
- R5: With `cfgInterleave`=1, beat i carries column s XOR i.
- R6: A read beat issued at edge t is delivered after edge t+3: `rdValid`=1, `rdData` lanes taken from `dqIn` at edge t+3, `rdCol` its column. `dqOe` stays 0 during reads.
- R7: `dqmOut` follows `hostMask` in every cycle. A mask bit set at edge e makes the matching lane of a word captured at edge e+2 read as zero with its `rdLaneOk` bit 0. Unmasked lanes of a delivered word have `rdLaneOk` 1.
- R8: `cmdStop` at edge s with no new command suppresses beats at edge s and later. Read beats issued before s are still delivered.
- R9: A read or write command during a burst ends the old burst at once and starts the new one from beat 0 with its own start column, length and order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdRead | input | 1 | Read command issued this cycle |
| cmdWrite | input | 1 | Write command issued this cycle |
| cmdStop | input | 1 | Burst-stop command issued this cycle |
| cmdCol | input | 3 | Low column bits of the starting address |
| cfgBurst | input | 2 | Burst length code, length 2^code |
| cfgInterleave | input | 1 | 1 selects interleaved column order |
| hostMask | input | 8 | Byte-lane mask for the current cycle |
| hostWrData | input | 64 | Write word for the current beat |
| wrTake | output | 1 | Current cycle is a write beat; host word is consumed |
| beatCol | output | 3 | Column of the beat issued this cycle |
| dqOut | output | 64 | Data driven toward the memory |
| dqOe | output | 8 | Per-lane output enable |
| dqmOut | output | 8 | Byte-mask lines to the memory |
| dqIn | input | 64 | Data arriving from the memory |
| rdValid | output | 1 | A read word is delivered this cycle |
| rdData | output | 64 | Delivered read word, masked lanes zero |
| rdLaneOk | output | 8 | Per-lane validity of the delivered word |
| rdCol | output | 3 | Column of the delivered read word |

## Verification
Two things can land on the same edge. One is a burst stop, or a fresh command, that truncates the issuing side of a read. The other is the capture of earlier read beats still in the CAS pipeline. The bench issues stops and restarts one to three cycles after a read or write starts, while masks vary every cycle. It judges the result by counting delivered words and their columns against the arithmetic schedule. Issued beats must still arrive with the mask that was present two edges before their capture, and none may arrive after the cut.

// File: rtl/sdp_pkg.sv
package sdp_pkg;
  // widest burst is 2**COL_BITS beats
  localparam int COL_BITS = 3;

  typedef struct packed {
    logic                wrBeat;
    logic                rdBeat;
    logic [COL_BITS-1:0] col;
  } dpStrobe_t;
endpackage

// File: rtl/sdp_ctrl.sv
module sdp_ctrl
  import sdp_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                cmdRead,
  input  logic                cmdWrite,
  input  logic                cmdStop,
  input  logic [COL_BITS-1:0] cmdCol,
  input  logic [1:0]          cfgBurst,
  input  logic                cfgInterleave,
  output dpStrobe_t           strobe
);
  localparam int CNT_W = COL_BITS + 1;

  logic                busyQ, rdQ, ilvQ;
  logic [COL_BITS-1:0] startQ, lenMaskQ, idxQ, leftQ;

  logic                newCmd, beatOn, useRd, useIlv;
  logic [COL_BITS-1:0] lenMaskNew, useStart, useMask, useIdx, seqCol, ilvCol;

  always_comb begin
    newCmd     = cmdRead | cmdWrite;
    lenMaskNew = COL_BITS'((CNT_W'(1) << cfgBurst) - CNT_W'(1));
    beatOn     = newCmd | (busyQ & ~cmdStop);
    useRd      = newCmd ? cmdRead       : rdQ;
    useIlv     = newCmd ? cfgInterleave : ilvQ;
    useStart   = newCmd ? cmdCol        : startQ;
    useMask    = newCmd ? lenMaskNew    : lenMaskQ;
    useIdx     = newCmd ? '0            : idxQ;
    // sequential order wraps inside the aligned block of the burst length
    seqCol     = (useStart & ~useMask) | ((useStart + useIdx) & useMask);
    ilvCol     = useStart ^ useIdx;
    strobe.col    = useIlv ? ilvCol : seqCol;
    strobe.wrBeat = beatOn & ~useRd;
    strobe.rdBeat = beatOn & useRd;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ    <= 1'b0;
      rdQ      <= 1'b0;
      ilvQ     <= 1'b0;
      startQ   <= '0;
      lenMaskQ <= '0;
      idxQ     <= '0;
      leftQ    <= '0;
    end else if (newCmd) begin
      // remaining beats after beat 0 equals the length mask
      busyQ    <= (lenMaskNew != '0);
      leftQ    <= lenMaskNew;
      idxQ     <= COL_BITS'(1);
      rdQ      <= cmdRead;
      ilvQ     <= cfgInterleave;
      startQ   <= cmdCol;
      lenMaskQ <= lenMaskNew;
    end else if (busyQ) begin
      if (cmdStop) begin
        busyQ <= 1'b0;
      end else begin
        idxQ  <= idxQ + COL_BITS'(1);
        leftQ <= leftQ - COL_BITS'(1);
        busyQ <= (leftQ != COL_BITS'(1));
      end
    end
  end

  // beats issued since the last command, for the length bound check
  logic [CNT_W-1:0] runLen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       runLen <= '0;
    else if (newCmd) runLen <= CNT_W'(1);
    else if (beatOn) runLen <= runLen + CNT_W'(1);
  end

  // R3: a burst never exceeds the widest length
  a_r3_burst_bounded: assert property (@(posedge clk) disable iff (!rstN)
    (beatOn && !newCmd) |-> (runLen < CNT_W'(1 << COL_BITS)));

  // R8: after a stop no beat follows unless a new command arrives
  a_r8_stop_halts: assert property (@(posedge clk) disable iff (!rstN)
    (cmdStop && !newCmd) |=>
      (!(strobe.wrBeat || strobe.rdBeat) || cmdRead || cmdWrite));
endmodule

// File: rtl/sdp_data.sv
module sdp_data
  import sdp_pkg::*;
#(
  parameter int DATA_W     = 64,
  parameter int LANES      = 8,
  parameter int CAS_LAT    = 3,
  parameter int RD_DQM_LAT = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobe_t           strobe,
  input  logic [LANES-1:0]    hostMask,
  input  logic [DATA_W-1:0]   hostWrData,
  input  logic [DATA_W-1:0]   dqIn,
  output logic [DATA_W-1:0]   dqOut,
  output logic [LANES-1:0]    dqOe,
  output logic [LANES-1:0]    dqmOut,
  output logic                rdValid,
  output logic [DATA_W-1:0]   rdData,
  output logic [LANES-1:0]    rdLaneOk,
  output logic [COL_BITS-1:0] rdCol
);
  localparam int LANE_W = DATA_W / LANES;

  // write side: mask applies to the very edge it is sampled on
  assign dqmOut = hostMask;
  assign dqOut  = strobe.wrBeat ? hostWrData : '0;
  assign dqOe   = strobe.wrBeat ? ~hostMask : '0;

  // read side: issued beats ride a CAS-length pipeline, masks a shorter one
  logic [CAS_LAT-1:0]    pipeV;
  logic [COL_BITS-1:0]   pipeCol [CAS_LAT];
  logic [LANES-1:0]      maskPipe [RD_DQM_LAT];
  logic [LANES-1:0]      laneUse;
  logic [DATA_W-1:0]     capWord;

  assign laneUse = pipeV[CAS_LAT-1] ? ~maskPipe[RD_DQM_LAT-1] : '0;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign capWord[l*LANE_W +: LANE_W] =
      laneUse[l] ? dqIn[l*LANE_W +: LANE_W] : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pipeV    <= '0;
      for (int s = 0; s < CAS_LAT; s++)    pipeCol[s]  <= '0;
      for (int s = 0; s < RD_DQM_LAT; s++) maskPipe[s] <= '0;
      rdValid  <= 1'b0;
      rdData   <= '0;
      rdLaneOk <= '0;
      rdCol    <= '0;
    end else begin
      pipeV[0]    <= strobe.rdBeat;
      pipeCol[0]  <= strobe.col;
      maskPipe[0] <= hostMask;
      for (int s = 1; s < CAS_LAT; s++) begin
        pipeV[s]   <= pipeV[s-1];
        pipeCol[s] <= pipeCol[s-1];
      end
      for (int s = 1; s < RD_DQM_LAT; s++) maskPipe[s] <= maskPipe[s-1];
      rdValid  <= pipeV[CAS_LAT-1];
      rdCol    <= pipeCol[CAS_LAT-1];
      rdLaneOk <= laneUse;
      rdData   <= capWord;
    end
  end

  // R6: every issued read beat is delivered CAS latency edges later
  a_r6_cas_delivery: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rdBeat |-> ##(CAS_LAT+1) rdValid);

  // R7: a lane masked two edges before capture never reports valid
  a_r7_read_mask_lag: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> ((rdLaneOk & $past(dqmOut, RD_DQM_LAT+1)) == '0));
endmodule

// File: rtl/sdram_datapath.sv
module sdram_datapath
  import sdp_pkg::*;
#(
  parameter int DATA_W     = 64,
  parameter int LANES      = 8,
  parameter int CAS_LAT    = 3,
  parameter int RD_DQM_LAT = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cmdRead,
  input  logic                cmdWrite,
  input  logic                cmdStop,
  input  logic [COL_BITS-1:0] cmdCol,
  input  logic [1:0]          cfgBurst,
  input  logic                cfgInterleave,
  input  logic [LANES-1:0]    hostMask,
  input  logic [DATA_W-1:0]   hostWrData,
  output logic                wrTake,
  output logic [COL_BITS-1:0] beatCol,
  output logic [DATA_W-1:0]   dqOut,
  output logic [LANES-1:0]    dqOe,
  output logic [LANES-1:0]    dqmOut,
  input  logic [DATA_W-1:0]   dqIn,
  output logic                rdValid,
  output logic [DATA_W-1:0]   rdData,
  output logic [LANES-1:0]    rdLaneOk,
  output logic [COL_BITS-1:0] rdCol
);
  dpStrobe_t strobe;

  sdp_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .cmdRead(cmdRead), .cmdWrite(cmdWrite), .cmdStop(cmdStop),
    .cmdCol(cmdCol), .cfgBurst(cfgBurst), .cfgInterleave(cfgInterleave),
    .strobe(strobe)
  );

  sdp_data #(
    .DATA_W(DATA_W), .LANES(LANES), .CAS_LAT(CAS_LAT), .RD_DQM_LAT(RD_DQM_LAT)
  ) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .hostMask(hostMask), .hostWrData(hostWrData), .dqIn(dqIn),
    .dqOut(dqOut), .dqOe(dqOe), .dqmOut(dqmOut),
    .rdValid(rdValid), .rdData(rdData), .rdLaneOk(rdLaneOk), .rdCol(rdCol)
  );

  assign wrTake  = strobe.wrBeat;
  assign beatCol = strobe.col;
endmodule

// File: tb/sdram_datapath_bench.sv
module sdram_datapath_bench;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rstN = 1'b0;
  logic cmdRead = 0, cmdWrite = 0, cmdStop = 0, cfgInterleave = 0;
  logic [2:0] cmdCol = '0;
  logic [1:0] cfgBurst = '0;
  logic [7:0] hostMask = '0;
  logic [63:0] hostWrData = '0, dqIn = '0;
  logic wrTake, rdValid;
  logic [2:0] beatCol, rdCol;
  logic [63:0] dqOut, rdData;
  logic [7:0] dqOe, dqmOut, rdLaneOk;

  int checks = 0, failures = 0, testNo = 0;
  bit done = 0;

  sdram_datapath u_sdram_datapath (
    .clk(clk), .rstN(rstN), .cmdRead(cmdRead), .cmdWrite(cmdWrite),
    .cmdStop(cmdStop), .cmdCol(cmdCol), .cfgBurst(cfgBurst),
    .cfgInterleave(cfgInterleave), .hostMask(hostMask), .hostWrData(hostWrData),
    .wrTake(wrTake), .beatCol(beatCol), .dqOut(dqOut), .dqOe(dqOe),
    .dqmOut(dqmOut), .dqIn(dqIn), .rdValid(rdValid), .rdData(rdData),
    .rdLaneOk(rdLaneOk), .rdCol(rdCol)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s test=%0d actual=%h expected=%h", tag, testNo, act, exp);
    end
  endtask

  function automatic logic [2:0] colOf(input int cfg, input int ilv,
                                       input int col, input int i);
    int len = 1 << cfg;
    if (ilv != 0) return 3'(col ^ i);
    return 3'((col & ~(len - 1)) | ((col + i) & (len - 1)));
  endfunction

  function automatic logic [63:0] spread(input logic [7:0] m);
    logic [63:0] r;
    for (int l = 0; l < 8; l++) r[l*8 +: 8] = {8{m[l]}};
    return r;
  endfunction

  function automatic logic [7:0] maskOf(input int k);
    if (k % 5 == 0) return 8'h00;
    if (k % 7 == 3) return 8'hFF;
    return 8'(k * 91 + testNo * 61);
  endfunction

  function automatic logic [63:0] dataOf(input int k);
    return 64'hA5C3_0F1E_7788_1234 ^ (64'(testNo) << 20) ^ 64'(k * 40503 + 7);
  endfunction

  task automatic runWrite(input int cfg, input int ilv, input int col,
                          input int stopAt);
    int len = 1 << cfg;
    testNo++;
    for (int k = 0; k <= len; k++) begin
      bit expB;
      @(negedge clk);
      cmdWrite = (k == 0); cmdStop = (k == stopAt);
      cmdCol = 3'(col); cfgBurst = 2'(cfg); cfgInterleave = ilv[0];
      hostMask = maskOf(k); hostWrData = dataOf(k);
      #1;
      expB = (k < len) && (stopAt < 0 || k < stopAt);
      chk(wrTake == expB, "R2/R3/R8 write beat", 64'(wrTake), 64'(expB));
      if (expB) begin
        chk(beatCol == colOf(cfg, ilv, col, k), ilv ? "R5 write col" : "R4 write col",
            64'(beatCol), 64'(colOf(cfg, ilv, col, k)));
        chk(dqOut == hostWrData, "R2 write data", dqOut, hostWrData);
        chk(dqOe == ~hostMask, "R2 write lane enable", 64'(dqOe), 64'(~hostMask));
      end else begin
        chk(dqOe == 8'h00, "R2 bus released", 64'(dqOe), 64'h0);
      end
    end
    cmdWrite = 0; cmdStop = 0;
  endtask

  task automatic runRead(input int cfg, input int ilv, input int col,
                         input int stopAt);
    int len = 1 << cfg;
    logic [63:0] dArr [16];
    logic [7:0]  mArr [16];
    testNo++;
    for (int k = 0; k <= len + 4; k++) begin
      @(negedge clk);
      cmdRead = (k == 0); cmdStop = (k == stopAt);
      cmdCol = 3'(col); cfgBurst = 2'(cfg); cfgInterleave = ilv[0];
      hostMask = maskOf(k); dqIn = dataOf(k);
      dArr[k] = dqIn; mArr[k] = hostMask;
      #1;
      chk(dqmOut == hostMask, "R7 mask passthrough", 64'(dqmOut), 64'(hostMask));
      chk(dqOe == 8'h00, "R6 no drive during read", 64'(dqOe), 64'h0);
      if (k >= 4) begin
        int i = k - 4;
        bit expV = (i < len) && (stopAt < 0 || i < stopAt);
        chk(rdValid == expV, "R6/R3/R8 read delivery", 64'(rdValid), 64'(expV));
        if (expV) begin
          logic [63:0] expD = dArr[k-1] & ~spread(mArr[k-3]);
          chk(rdCol == colOf(cfg, ilv, col, i), ilv ? "R5 read col" : "R4 read col",
              64'(rdCol), 64'(colOf(cfg, ilv, col, i)));
          chk(rdData == expD, "R6/R7 read data", rdData, expD);
          chk(rdLaneOk == ~mArr[k-3], "R7 lane valid", 64'(rdLaneOk), 64'(~mArr[k-3]));
        end
      end else begin
        chk(rdValid == 1'b0, "R6 no early word", 64'(rdValid), 64'h0);
      end
    end
    cmdRead = 0; cmdStop = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(rdValid == 0 && wrTake == 0 && dqOe == 0, "R1 in reset",
        {rdValid, wrTake, dqOe}, 64'h0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    chk(rdValid == 0 && wrTake == 0 && dqOe == 0, "R1 after reset",
        {rdValid, wrTake, dqOe}, 64'h0);

    for (int cfg = 0; cfg < 4; cfg++)
      for (int ilv = 0; ilv < 2; ilv++)
        for (int col = 0; col < 8; col++) begin
          runWrite(cfg, ilv, col, -1);
          runRead(cfg, ilv, col, -1);
        end

    // burst stop while earlier read beats are still in flight
    runRead(3, 0, 5, 3);
    runRead(2, 1, 2, 1);
    runWrite(3, 1, 3, 2);

    // R9: write of 8 restarted by interleaved write of 4 at column 6
    testNo++;
    begin
      int expCols [6] = '{0, 1, 6, 7, 4, 5};
      for (int k = 0; k <= 6; k++) begin
        @(negedge clk);
        cmdWrite = (k == 0 || k == 2);
        cmdCol = (k == 2) ? 3'd6 : 3'd0;
        cfgBurst = (k == 2) ? 2'd2 : 2'd3;
        cfgInterleave = (k == 2);
        hostMask = 8'h00; hostWrData = dataOf(k);
        #1;
        chk(wrTake == (k < 6), "R9 restart beat", 64'(wrTake), 64'(k < 6));
        if (k < 6)
          chk(beatCol == expCols[k], "R9 restart col", 64'(beatCol), 64'(expCols[k]));
      end
      cmdWrite = 0;
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule